// File: doc/BRIEF.md
# Photovoltaic Converter Mode Sequencer

This block is the operating-mode state machine for a four-switch buck-boost stage behind a solar panel. It decides, from a millisecond timebase, the sampled output current and output power, a flag that reports a 1:1 conversion ratio, and two pins (an active-low hold and an active-low force-panel request), whether the stage is idle, ramping up, waiting to go to pass-through, sitting in pass-through (panel) mode, or letting the maximum-power-point tracker run. The tracker, the PWM generator and the converter front end live elsewhere. This block only tells them which mode is in force.

After a fixed ramp, the sequencer either starts tracking at once or waits in a pass-through start phase. Leaving tracking for pass-through happens after the converter has stayed at 1:1 for a selectable time. Pass-through is left for a bounded re-check at a fixed period, or for open-ended tracking when output power drifts from its value at entry by more than a selectable fraction. Output-current thresholds for tracking are hysteretic.

All timers count `tick_ms` pulses. Durations are parameters in milliseconds, so a small build can run with short windows.

Top module: `pv_mode_seq`

## Requirements
- R1: While `rst` is high, or in the clock after `hold_n` is sampled low, `mode` is 0 (idle) and `mppt_en` and `panel_req` are 0. The block stays idle while `hold_n` is low. In the first clock with `hold_n` high it enters `mode` 1 (ramp).
- R2: The ramp lasts exactly SOFT_MS tick cycles. With `tick_ms` held high, `mode` leaves 1 on the SOFT_MS-th clock edge after entering it.
- R3: At the end of the ramp, `mode` becomes 4 (tracking) if `iout` was strictly above `thr_start` in any ramp cycle. Otherwise it becomes 2 (pass-through start). A current equal to `thr_start` does not count.
- R4: In `mode` 2 the start timer counts only from the first cycle in which `iout` is strictly above `thr_start`, and it keeps counting if the current later falls. `cfg_start_sel` chooses the starting time: 0 gives 0 ms, 1 gives START_UNIT_MS, 2 gives twice START_UNIT_MS, and 3 gives START_UNIT_MS. When the time is reached, `mode` becomes 3 (panel), at the earliest on the first armed edge.
- R5: In `mode` 4, an `iout` strictly below `thr_exit` moves the block to `mode` 2 on the next edge. At or above `thr_exit`, tracking continues.
- R6: In `mode` 4, `at_unity` held high for a run of tick cycles moves the block to `mode` 3. The run length is chosen by `cfg_unity_sel`: 0 gives 1, 1 gives 2, 2 gives 5 and 3 gives 10 times UNITY_BASE_MS. One low cycle restarts the run.
- R7: After RECHECK_MS tick cycles in `mode` 3, the block enters `mode` 4 for a bounded re-check. After WINDOW_MS tick cycles it returns to `mode` 3, unless another exit applies first.
- R8: The output power is captured as a baseline on the edge that enters `mode` 3. A later `pout` with absolute difference from the baseline strictly greater than the baseline shifted right by 5 (`cfg_fine_pwr`=0) or by 6 (`cfg_fine_pwr`=1) moves the block to unbounded `mode` 4 on the next edge.
- R9: A force request moves the block from modes 1, 2 or 4 to `mode` 3 on the next edge. While the request lasts, the block stays in `mode` 3 with no re-check and no power exit. The re-check timer and the power baseline restart in every forced cycle.
- R10: With `pin_override` high, the force request is `pin_override_val` (1 forces) and `panel_pin_n` is ignored. With `pin_override` low, the request is `panel_pin_n` low.
- R11: `mode` is always one of the codes 0 to 4. `mppt_en` is high exactly when `mode` is 4. `panel_req` is high exactly when `mode` is 2 or 3.
- R12: Timers advance only in cycles with `tick_ms` high. A ramp with `tick_ms` high on alternate cycles, starting high, lasts 2*SOFT_MS-1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| hold_n | input | 1 | Active-low hold; low forces idle |
| panel_pin_n | input | 1 | Active-low force-panel pin |
| pin_override | input | 1 | Selects the register value instead of the pin |
| pin_override_val | input | 1 | Register force value, 1 = force panel |
| iout | input | CUR_W | Sampled output current |
| pout | input | PWR_W | Sampled output power |
| at_unity | input | 1 | Converter is at a 1:1 ratio |
| cfg_start_sel | input | 2 | Starting panel time code |
| cfg_unity_sel | input | 2 | Time-at-1:1 code |
| cfg_fine_pwr | input | 1 | Power change fraction: 0 = 1/32, 1 = 1/64 |
| thr_start | input | CUR_W | Tracking start current threshold |
| thr_exit | input | CUR_W | Tracking exit current threshold |
| mode | output | 3 | Mode code 0 idle, 1 ramp, 2 pass-through start, 3 panel, 4 tracking |
| mppt_en | output | 1 | Tracker enable |
| panel_req | output | 1 | Pass-through switch request |

## Verification
A wrong internal state shows up at the ports in two ways. The `mode` code can take an unexpected value, or it can change one or more edges too early or too late. Every transition is registered, so a wrong next-state decision is visible one edge after the deciding input.

Timer faults (an off-by-one limit, a missed clear, counting without a tick) only appear as a dwell length that differs from the computed value. For that reason the dwell of each timed mode is measured in edges across every selector code. A stale power baseline or a lost arming latch stays hidden until a later stimulus. The bench therefore changes power and current after entry and checks the mode a few edges later.

// File: rtl/pv_seq_pkg.sv
package pv_seq_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_RAMP      = 3'd1,
    MODE_PASS_WAIT = 3'd2,
    MODE_PASS      = 3'd3,
    MODE_TRACK     = 3'd4
  } pv_mode_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pv_ms_timer.sv
// Saturating millisecond counter; hit means the limit is met including this cycle's increment.
module pv_ms_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt;
  logic [W:0]   cnt_next;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != {W{1'b1}})) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cnt_next = {1'b0, cnt} + {{W{1'b0}}, inc};
  assign hit      = (cnt_next >= {1'b0, limit});

endmodule

// File: rtl/pv_limit_decode.sv
// Turns the configuration codes into millisecond limits.
module pv_limit_decode #(
  parameter int          W             = 17,
  parameter int unsigned START_UNIT_MS = 60000,
  parameter int unsigned UNITY_BASE_MS = 200
) (
  input  logic [1:0]   start_sel,
  input  logic [1:0]   unity_sel,
  output logic [W-1:0] start_lim,
  output logic [W-1:0] unity_lim
);

  localparam logic [W-1:0] START_ONE = W'(START_UNIT_MS);
  localparam logic [W-1:0] START_TWO = W'(2 * START_UNIT_MS);
  localparam logic [W-1:0] UNITY_X1  = W'(UNITY_BASE_MS);
  localparam logic [W-1:0] UNITY_X2  = W'(2 * UNITY_BASE_MS);
  localparam logic [W-1:0] UNITY_X5  = W'(5 * UNITY_BASE_MS);
  localparam logic [W-1:0] UNITY_X10 = W'(10 * UNITY_BASE_MS);

  always_comb begin
    case (start_sel)
      2'd0:    start_lim = '0;
      2'd1:    start_lim = START_ONE;
      2'd2:    start_lim = START_TWO;
      default: start_lim = START_ONE;
    endcase
  end

  always_comb begin
    case (unity_sel)
      2'd0:    unity_lim = UNITY_X1;
      2'd1:    unity_lim = UNITY_X2;
      2'd2:    unity_lim = UNITY_X5;
      default: unity_lim = UNITY_X10;
    endcase
  end

endmodule

// File: rtl/pv_power_watch.sv
// Holds the power baseline and flags a drift beyond the selected fraction of it.
module pv_power_watch #(
  parameter int PW           = 16,
  parameter int COARSE_SHIFT = 5,
  parameter int FINE_SHIFT   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [PW-1:0] pwr,
  input  logic          fine_sel,
  output logic          moved
);

  logic [PW-1:0] base_q;
  logic [PW-1:0] diff;
  logic [PW-1:0] band;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (capture) begin
      base_q <= pwr;
    end
  end

  always_comb begin
    diff  = (pwr >= base_q) ? (pwr - base_q) : (base_q - pwr);
    band  = fine_sel ? (base_q >> FINE_SHIFT) : (base_q >> COARSE_SHIFT);
    moved = (diff > band);
  end

endmodule

// File: rtl/pv_mode_seq.sv
module pv_mode_seq
  import pv_seq_pkg::*;
#(
  parameter int          CUR_W         = 10,
  parameter int          PWR_W         = 16,
  parameter int unsigned SOFT_MS       = 250,
  parameter int unsigned START_UNIT_MS = 60000,
  parameter int unsigned RECHECK_MS    = 60000,
  parameter int unsigned WINDOW_MS     = 4000,
  parameter int unsigned UNITY_BASE_MS = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_ms,
  input  logic             hold_n,
  input  logic             panel_pin_n,
  input  logic             pin_override,
  input  logic             pin_override_val,
  input  logic [CUR_W-1:0] iout,
  input  logic [PWR_W-1:0] pout,
  input  logic             at_unity,
  input  logic [1:0]       cfg_start_sel,
  input  logic [1:0]       cfg_unity_sel,
  input  logic             cfg_fine_pwr,
  input  logic [CUR_W-1:0] thr_start,
  input  logic [CUR_W-1:0] thr_exit,
  output logic [2:0]       mode,
  output logic             mppt_en,
  output logic             panel_req
);

  localparam int unsigned LONGEST = max_u(max_u(SOFT_MS, 2 * START_UNIT_MS),
                                          max_u(max_u(RECHECK_MS, WINDOW_MS), 10 * UNITY_BASE_MS));
  localparam int TW = $clog2(LONGEST + 2);

  localparam logic [TW-1:0] SOFT_LIM    = TW'(SOFT_MS);
  localparam logic [TW-1:0] RECHECK_LIM = TW'(RECHECK_MS);
  localparam logic [TW-1:0] WINDOW_LIM  = TW'(WINDOW_MS);

  pv_mode_e st, nxt;

  logic          force_req;
  logic          above_start;
  logic          below_exit;
  logic          seen_q;
  logic          armed_q;
  logic          armed_now;
  logic          recheck_q;
  logic          recheck_nxt;
  logic          mppt_q;
  logic          panel_q;

  logic [TW-1:0] start_lim;
  logic [TW-1:0] unity_lim;
  logic [TW-1:0] stg_lim;
  logic          stg_clr;
  logic          stg_inc;
  logic          stg_hit;
  logic          uty_clr;
  logic          uty_hit;
  logic          pwr_capture;
  logic          pwr_moved;

  assign force_req   = pin_override ? pin_override_val : ~panel_pin_n;
  assign above_start = (iout > thr_start);
  assign below_exit  = (iout < thr_exit);
  assign armed_now   = armed_q | above_start;

  pv_limit_decode #(
    .W             (TW),
    .START_UNIT_MS (START_UNIT_MS),
    .UNITY_BASE_MS (UNITY_BASE_MS)
  ) lim_i (
    .start_sel (cfg_start_sel),
    .unity_sel (cfg_unity_sel),
    .start_lim (start_lim),
    .unity_lim (unity_lim)
  );

  // Stage timer: ramp length, start time, re-check period, re-check window.
  always_comb begin
    stg_lim = SOFT_LIM;
    stg_inc = 1'b0;
    case (st)
      MODE_RAMP: begin
        stg_lim = SOFT_LIM;
        stg_inc = tick_ms;
      end
      MODE_PASS_WAIT: begin
        stg_lim = start_lim;
        stg_inc = tick_ms & armed_now;
      end
      MODE_PASS: begin
        stg_lim = RECHECK_LIM;
        stg_inc = tick_ms;
      end
      MODE_TRACK: begin
        stg_lim = WINDOW_LIM;
        stg_inc = tick_ms & recheck_q;
      end
      default: begin
        stg_lim = SOFT_LIM;
        stg_inc = 1'b0;
      end
    endcase
  end

  assign stg_clr = (nxt != st) || (st == MODE_IDLE) ||
                   ((st == MODE_PASS) && force_req) ||
                   ((st == MODE_TRACK) && !recheck_q);

  pv_ms_timer #(.W(TW)) stg_tmr_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (stg_clr),
    .inc   (stg_inc),
    .limit (stg_lim),
    .hit   (stg_hit)
  );

  // Unity-ratio run timer, active only while tracking.
  assign uty_clr = (st != MODE_TRACK) || (nxt != MODE_TRACK) || !at_unity;

  pv_ms_timer #(.W(TW)) uty_tmr_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (uty_clr),
    .inc   (tick_ms),
    .limit (unity_lim),
    .hit   (uty_hit)
  );

  // Baseline taken on panel entry and in every forced panel cycle.
  assign pwr_capture = (nxt == MODE_PASS) && ((st != MODE_PASS) || force_req);

  pv_power_watch #(.PW(PWR_W)) pwr_i (
    .clk      (clk),
    .rst      (rst),
    .capture  (pwr_capture),
    .pwr      (pout),
    .fine_sel (cfg_fine_pwr),
    .moved    (pwr_moved)
  );

  // Next-state decision.
  always_comb begin
    nxt = st;
    if (!hold_n) begin
      nxt = MODE_IDLE;
    end else begin
      case (st)
        MODE_IDLE: nxt = MODE_RAMP;
        MODE_RAMP: begin
          if (force_req)    nxt = MODE_PASS;
          else if (stg_hit) nxt = (seen_q || above_start) ? MODE_TRACK : MODE_PASS_WAIT;
        end
        MODE_PASS_WAIT: begin
          if (force_req)                 nxt = MODE_PASS;
          else if (armed_now && stg_hit) nxt = MODE_PASS;
        end
        MODE_PASS: begin
          if (!force_req && (pwr_moved || stg_hit)) nxt = MODE_TRACK;
        end
        MODE_TRACK: begin
          if (force_req)                   nxt = MODE_PASS;
          else if (below_exit)             nxt = MODE_PASS_WAIT;
          else if (uty_hit && at_unity)    nxt = MODE_PASS;
          else if (recheck_q && stg_hit)   nxt = MODE_PASS;
        end
        default: nxt = MODE_IDLE;
      endcase
    end
  end

  // A re-check entry is bounded; a power-drift entry is not.
  always_comb begin
    recheck_nxt = 1'b0;
    if (nxt == MODE_TRACK) begin
      if (st == MODE_PASS)       recheck_nxt = !pwr_moved;
      else if (st == MODE_TRACK) recheck_nxt = recheck_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= MODE_IDLE;
      seen_q    <= 1'b0;
      armed_q   <= 1'b0;
      recheck_q <= 1'b0;
      mppt_q    <= 1'b0;
      panel_q   <= 1'b0;
    end else begin
      st        <= nxt;
      seen_q    <= (st == MODE_RAMP) && (nxt == MODE_RAMP) && (seen_q || above_start);
      armed_q   <= (st == MODE_PASS_WAIT) && (nxt == MODE_PASS_WAIT) && armed_now;
      recheck_q <= recheck_nxt;
      mppt_q    <= (nxt == MODE_TRACK);
      panel_q   <= (nxt == MODE_PASS) || (nxt == MODE_PASS_WAIT);
    end
  end

  assign mode      = st;
  assign mppt_en   = mppt_q;
  assign panel_req = panel_q;

endmodule

// File: rtl/pv_mode_seq_chk.sv
module pv_mode_seq_chk #(
  parameter int CUR_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             hold_n,
  input logic             panel_pin_n,
  input logic             pin_override,
  input logic             pin_override_val,
  input logic [CUR_W-1:0] iout,
  input logic [CUR_W-1:0] thr_exit,
  input logic [2:0]       mode,
  input logic             mppt_en,
  input logic             panel_req
);

  logic forced;
  assign forced = pin_override ? pin_override_val : !panel_pin_n;

  // R1
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> (mode == 3'd0) && !mppt_en && !panel_req);

  // R1
  idle_next_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0) |=> (mode == 3'd0) || (mode == 3'd1));

  // R11
  mode_code_chk: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd4);

  // R11
  track_flag_chk: assert property (@(posedge clk) disable iff (rst)
    mppt_en == (mode == 3'd4));

  // R11
  panel_flag_chk: assert property (@(posedge clk) disable iff (rst)
    panel_req == ((mode == 3'd2) || (mode == 3'd3)));

  // R9
  force_panel_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_n && forced && ((mode == 3'd1) || (mode == 3'd2) || (mode == 3'd4))) |=> (mode == 3'd3));

  // R5
  track_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_n && !forced && (mode == 3'd4) && (iout < thr_exit)) |=> (mode == 3'd2));

endmodule

bind pv_mode_seq pv_mode_seq_chk #(.CUR_W(CUR_W)) chk_i (
  .clk              (clk),
  .rst              (rst),
  .hold_n           (hold_n),
  .panel_pin_n      (panel_pin_n),
  .pin_override     (pin_override),
  .pin_override_val (pin_override_val),
  .iout             (iout),
  .thr_exit         (thr_exit),
  .mode             (mode),
  .mppt_en          (mppt_en),
  .panel_req        (panel_req)
);

// File: tb/pv_mode_seq_tb.sv
module pv_mode_seq_tb_top;

  localparam int SOFT   = 12;
  localparam int SUNIT  = 20;
  localparam int RECHK  = 50;
  localparam int WIN    = 9;
  localparam int UBASE  = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ms = 1'b1;
  logic       hold_n = 1'b1;
  logic       panel_pin_n = 1'b1;
  logic       pin_override = 1'b0;
  logic       pin_override_val = 1'b0;
  logic [9:0] iout = '0;
  logic [15:0] pout = 16'd1024;
  logic       at_unity = 1'b0;
  logic [1:0] cfg_start_sel = 2'd0;
  logic [1:0] cfg_unity_sel = 2'd0;
  logic       cfg_fine_pwr = 1'b0;
  logic [9:0] thr_start = 10'd500;
  logic [9:0] thr_exit = 10'd300;
  logic [2:0] mode;
  logic       mppt_en;
  logic       panel_req;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  pv_mode_seq #(
    .CUR_W(10), .PWR_W(16), .SOFT_MS(SOFT), .START_UNIT_MS(SUNIT),
    .RECHECK_MS(RECHK), .WINDOW_MS(WIN), .UNITY_BASE_MS(UBASE)
  ) dut_i (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .hold_n(hold_n),
    .panel_pin_n(panel_pin_n), .pin_override(pin_override),
    .pin_override_val(pin_override_val), .iout(iout), .pout(pout),
    .at_unity(at_unity), .cfg_start_sel(cfg_start_sel),
    .cfg_unity_sel(cfg_unity_sel), .cfg_fine_pwr(cfg_fine_pwr),
    .thr_start(thr_start), .thr_exit(thr_exit), .mode(mode),
    .mppt_en(mppt_en), .panel_req(panel_req)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_change(output int n, input bit toggle_tick);
    logic [2:0] m;
    m = mode;
    n = 0;
    do begin
      step();
      n++;
      if (toggle_tick) tick_ms = ~tick_ms;
    end while (mode == m && n < 500);
  endtask

  // Reset, release, and run the ramp out; ramp_n returns its length in edges.
  task automatic boot(input logic [9:0] cur, output int ramp_n);
    rst = 1'b1; hold_n = 1'b1; panel_pin_n = 1'b1; pin_override = 1'b0;
    pin_override_val = 1'b0; tick_ms = 1'b1; at_unity = 1'b0;
    iout = cur; pout = 16'd1024;
    step(); step();
    rst = 1'b0;
    step();
    wait_change(ramp_n, 1'b0);
  endtask

  task automatic to_panel();
    int n;
    cfg_start_sel = 2'd0;
    boot(10'd0, n);
    iout = 10'd600;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    int lim;
    int th;
    int d;
    int ulim;

    // R1 / R11: reset state
    step(); step();
    check("R1 reset mode", mode, 0);
    check("R1 reset mppt_en", mppt_en, 0);
    check("R1 reset panel_req", panel_req, 0);

    // R1 / R2 / R3: ramp length and low-current exit
    rst = 1'b0;
    step();
    check("R1 enter ramp", mode, 1);
    wait_change(n, 1'b0);
    check("R2 ramp length", n, SOFT);
    check("R3 low current to pass wait", mode, 2);
    check("R11 panel_req in wait", panel_req, 1);

    // R3 boundary: equal does not count, one above does
    boot(10'd500, n);
    check("R3 equal threshold", mode, 2);
    boot(10'd501, n);
    check("R3 above threshold", mode, 4);
    check("R11 mppt_en tracking", mppt_en, 1);

    // R4: start time sweep with arming latch
    for (int s = 0; s < 4; s++) begin
      cfg_start_sel = s[1:0];
      lim = (s == 0) ? 0 : (s == 2) ? 2 * SUNIT : SUNIT;
      boot(10'd0, n);
      iout = 10'd500;
      repeat (30) step();
      check("R4 unarmed holds", mode, 2);
      iout = 10'd501;
      step();
      n = 1;
      iout = 10'd0;
      if (mode == 3'd2) begin
        wait_change(d, 1'b0);
        n += d;
      end
      check("R4 start time", n, (lim < 1) ? 1 : lim);
      check("R4 reaches panel", mode, 3);
    end

    // R8: power drift sweep on both fractions
    for (int f = 0; f < 2; f++) begin
      th = (f == 0) ? 1024 / 32 : 1024 / 64;
      for (int k = 0; k < 4; k++) begin
        d = (k == 0) ? th : (k == 1) ? th + 1 : (k == 2) ? -th : -(th + 1);
        cfg_fine_pwr = f[0];
        to_panel();
        pout = 16'(1024 + d);
        step();
        check("R8 power drift", mode, ((k == 1) || (k == 3)) ? 4 : 3);
        if ((k == 0) || (k == 2)) begin
          step(); step();
          check("R8 inside band stays", mode, 3);
        end
      end
    end
    cfg_fine_pwr = 1'b0;

    // R7: periodic re-check, bounded window, baseline re-capture (R8)
    to_panel();
    wait_change(n, 1'b0);
    check("R7 recheck period", n, RECHK);
    check("R7 recheck tracking", mode, 4);
    pout = 16'd2000;
    wait_change(n, 1'b0);
    check("R7 window length", n, WIN);
    check("R7 back to panel", mode, 3);
    repeat (5) step();
    check("R8 baseline recaptured", mode, 3);

    // R6: unity dwell sweep
    for (int u = 0; u < 4; u++) begin
      cfg_unity_sel = u[1:0];
      ulim = UBASE * ((u == 0) ? 1 : (u == 1) ? 2 : (u == 2) ? 5 : 10);
      boot(10'd600, n);
      at_unity = 1'b1;
      wait_change(n, 1'b0);
      check("R6 unity dwell", n, ulim);
      check("R6 unity to panel", mode, 3);
    end
    cfg_unity_sel = 2'd1;
    boot(10'd600, n);
    at_unity = 1'b1;
    repeat (2 * UBASE - 1) step();
    at_unity = 1'b0;
    step();
    check("R6 run not complete", mode, 4);
    at_unity = 1'b1;
    wait_change(n, 1'b0);
    check("R6 run restarts", n, 2 * UBASE);
    at_unity = 1'b0;

    // R5: hysteresis
    boot(10'd600, n);
    iout = 10'd400; step(); step();
    check("R5 between thresholds", mode, 4);
    iout = 10'd300; step(); step();
    check("R5 at exit threshold", mode, 4);
    iout = 10'd299; step();
    check("R5 below exit", mode, 2);

    // R9: force from tracking, hold in panel, restart on release
    boot(10'd600, n);
    panel_pin_n = 1'b0;
    step();
    check("R9 force from tracking", mode, 3);
    pout = 16'd3000;
    repeat (60) step();
    check("R9 forced panel holds", mode, 3);
    panel_pin_n = 1'b1;
    wait_change(n, 1'b0);
    check("R9 recheck restarts after release", n, RECHK);
    // R9: force from ramp and from wait
    rst = 1'b1; step(); rst = 1'b0; step();
    panel_pin_n = 1'b0; step();
    check("R9 force from ramp", mode, 3);
    boot(10'd0, n);
    panel_pin_n = 1'b0; step();
    check("R9 force from wait", mode, 3);
    panel_pin_n = 1'b1;

    // R10: override source
    boot(10'd600, n);
    pin_override = 1'b1; pin_override_val = 1'b0; panel_pin_n = 1'b0;
    step(); step(); step();
    check("R10 pin ignored", mode, 4);
    panel_pin_n = 1'b1; pin_override_val = 1'b1;
    step();
    check("R10 override forces", mode, 3);
    pin_override = 1'b0; pin_override_val = 1'b0;

    // R1: hold from panel
    hold_n = 1'b0;
    step();
    check("R1 hold mode", mode, 0);
    check("R1 hold panel_req", panel_req, 0);
    check("R1 hold mppt_en", mppt_en, 0);
    repeat (5) step();
    check("R1 stays idle", mode, 0);
    hold_n = 1'b1;
    step();
    check("R1 release to ramp", mode, 1);

    // R12: tick gating
    rst = 1'b1; step(); rst = 1'b0; iout = '0;
    tick_ms = 1'b0;
    step();
    repeat (20) step();
    check("R12 no tick no progress", mode, 1);
    rst = 1'b1; step(); rst = 1'b0;
    step();
    tick_ms = 1'b1;
    wait_change(n, 1'b1);
    check("R12 alternate tick ramp", n, 2 * SOFT - 1);
    tick_ms = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule